// File: doc/BRIEF.md
# Bidirectional latch/register bus transceiver

This block joins two 18-bit ports, called A and B, with one storage element for each direction of transfer. Each direction has three controls of its own: a latch enable, a capture strobe and an output enable. Raising the latch enable makes the output follow the opposite port's input. With the latch enable low, the stored word is held until the capture strobe falls, and that falling edge loads a new word. The output enable of the A-to-B path is active-high. The output enable of the B-to-A path is active-low.

The block runs from a core clock. Both strobes are sampled on the rising edge of that clock. A strobe counts as falling when it was seen high at one edge and low at the next, and the word on the input at that second edge is stored. Each tri-state output is a pair: a data bus and an enable. When the enable is off, the data bus is all zeros. The storage keeps its contents while its output is off.

Each direction has a small mode machine, registered once per core clock. It has three states:
- `ST_FLOW`: the latch enable is high and the storage tracks the input.
- `ST_LOAD`: a strobe fall was seen with the latch enable low, and the input was loaded.
- `ST_HOLD`: nothing was written.

It moves on every edge: to `ST_FLOW` whenever the latch enable is high, otherwise to `ST_LOAD` when a strobe fall is seen, and otherwise to `ST_HOLD`. Reset enters `ST_HOLD`.

Top module: `ubt_xcvr`

## Requirements
- R1: With `ab_le`=1 and `ab_en`=1, `b_out` equals `a_in` in the same cycle and `b_oe`=1.
- R2: With `ab_le`=0 and `ab_strb` steady or rising, `b_out` keeps the stored word whatever `a_in` does.
- R3: With `ab_le`=0, when `ab_strb` is 1 at one core clock edge and 0 at the next, the `a_in` word at the second edge is stored and shows on `b_out` right after that edge.
- R4: With `ab_en`=0, `b_oe`=0 and `b_out` is all zeros.
- R5: With `ba_le`=1 and `ba_en_n`=0, `a_out` equals `b_in` in the same cycle and `a_oe`=1.
- R6: With `ba_le`=0, a falling `ba_strb` stores `b_in`, and `a_out` then holds that word while `ba_strb` is steady.
- R7: With `ba_en_n`=1, `a_oe`=0 and `a_out` is all zeros. The enable is active-low.
- R8: A capture made while a direction's output is off is kept, and it appears once the output is turned back on.
- R9: While a latch enable is high, the storage takes the input at every edge, and a falling strobe adds nothing more. After the latch enable drops, the word from the last edge at which it was high is held.
- R10: The active-low asynchronous `rst_n` clears both stored words to zero and clears the strobe history, so a strobe that is low at the first edge after release does not capture.
- R11: The controls and data of one direction never change the word stored in the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; strobes sampled on rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | 18 | Word received on port A |
| a_out | output | 18 | Word driven onto port A (zero when off) |
| a_oe | output | 1 | Drive enable for port A |
| b_in | input | 18 | Word received on port B |
| b_out | output | 18 | Word driven onto port B (zero when off) |
| b_oe | output | 1 | Drive enable for port B |
| ab_le | input | 1 | A-to-B latch enable, high = transparent |
| ab_strb | input | 1 | A-to-B capture strobe, falling edge loads |
| ab_en | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch enable, high = transparent |
| ba_strb | input | 1 | B-to-A capture strobe, falling edge loads |
| ba_en_n | input | 1 | B-to-A output enable, active low |

## Verification
Two functions can fall in the same cycle:
- A strobe fall can land in the same cycle as the output enable going off. The bench provokes this by dropping the strobe while the enable is off. It then turns the enable back on and expects the word from that edge, not the older word.
- A falling strobe can land while the latch enable is high. The bench checks that the output stays on the live input. It then drops the latch enable and expects the word from the last transparent edge.

Both directions run from one table, with complementary data, so any leak between the two paths shows as a mismatch.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
    localparam int UBT_WIDTH = 18;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_FLOW = 2'd1,
        ST_LOAD = 2'd2
    } mode_e;
endpackage

// File: rtl/ubt_store.sv
module ubt_store
    import ubt_pkg::*;
#(
    parameter int W = UBT_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic         strb,
    input  logic [W-1:0] d,
    output logic [W-1:0] view
);
    mode_e        state;
    mode_e        nxt;
    logic         strb_q;
    logic         fall;
    logic [W-1:0] q;

    // next mode and output view
    always_comb begin
        fall = strb_q & ~strb;
        if (le)
            nxt = ST_FLOW;
        else if (fall)
            nxt = ST_LOAD;
        else
            nxt = ST_HOLD;
        view = le ? d : q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_HOLD;
            strb_q <= 1'b0;
            q      <= '0;
        end else begin
            state  <= nxt;
            strb_q <= strb;
            unique case (nxt)
                ST_FLOW, ST_LOAD: q <= d;
                default:          q <= q;
            endcase
        end
    end

    // R3 / R6: a load cycle holds the word present at the loading edge
    a_r3_load_word: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |-> (q == $past(d)));
    // R9: transparent cycles track the input edge by edge
    a_r9_flow_track: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLOW) |-> (q == $past(d)));
    // R2: a hold cycle leaves the stored word untouched
    a_r2_hold_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> $stable(q));
endmodule

// File: rtl/ubt_drive.sv
module ubt_drive #(
    parameter int W          = 18,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic         en_in,
    input  logic [W-1:0] word,
    output logic [W-1:0] out,
    output logic         oe
);
    logic on;

    generate
        if (ACTIVE_LOW) begin : g_low
            assign on = ~en_in;
        end else begin : g_high
            assign on = en_in;
        end
    endgenerate

    always_comb begin
        oe  = on;
        out = on ? word : '0;
    end
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr
    import ubt_pkg::*;
#(
    parameter int W = UBT_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    input  logic         ab_le,
    input  logic         ab_strb,
    input  logic         ab_en,
    input  logic         ba_le,
    input  logic         ba_strb,
    input  logic         ba_en_n
);
    logic [W-1:0] ab_word;
    logic [W-1:0] ba_word;

    ubt_store #(.W(W)) u_ab_store (
        .clk(clk), .rst_n(rst_n), .le(ab_le), .strb(ab_strb),
        .d(a_in), .view(ab_word)
    );

    ubt_store #(.W(W)) u_ba_store (
        .clk(clk), .rst_n(rst_n), .le(ba_le), .strb(ba_strb),
        .d(b_in), .view(ba_word)
    );

    ubt_drive #(.W(W), .ACTIVE_LOW(1'b0)) u_b_drive (
        .en_in(ab_en), .word(ab_word), .out(b_out), .oe(b_oe)
    );

    ubt_drive #(.W(W), .ACTIVE_LOW(1'b1)) u_a_drive (
        .en_in(ba_en_n), .word(ba_word), .out(a_out), .oe(a_oe)
    );

    // R1: transparent path from A to B
    a_r1_ab_flow: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_en && ab_le) |-> (b_oe && b_out == a_in));
    // R5: transparent path from B to A
    a_r5_ba_flow: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_en_n && ba_le) |-> (a_oe && a_out == b_in));
    // R4: B side released when its enable is low
    a_r4_b_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ab_en |-> (!b_oe && b_out == '0));
    // R7: A side released when its active-low enable is high
    a_r7_a_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ba_en_n |-> (!a_oe && a_out == '0));
endmodule

// File: tb/sim_ubt_xcvr.sv
module sim_ubt_xcvr;
    localparam int W    = 18;
    localparam int NV   = 13;
    localparam logic [W-1:0] MASK = {W{1'b1}};

    // vector: le, strb, en, din, expected oe, expected out
    typedef struct packed {
        logic         le;
        logic         strb;
        logic         en;
        logic [W-1:0] din;
        logic         eoe;
        logic [W-1:0] eout;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b1, 18'h12345, 1'b1, 18'h12345},  // R1
        '{1'b1, 1'b0, 1'b1, 18'h0ABCD, 1'b1, 18'h0ABCD},  // R1
        '{1'b0, 1'b0, 1'b1, 18'h3FFFF, 1'b1, 18'h0ABCD},  // R9 hold after le drop
        '{1'b0, 1'b1, 1'b1, 18'h15555, 1'b1, 18'h0ABCD},  // R2 rising strobe
        '{1'b0, 1'b1, 1'b1, 18'h2AAAA, 1'b1, 18'h0ABCD},  // R2 steady strobe
        '{1'b0, 1'b0, 1'b1, 18'h01111, 1'b1, 18'h01111},  // R3 capture
        '{1'b0, 1'b0, 1'b1, 18'h02222, 1'b1, 18'h01111},  // R2 hold
        '{1'b0, 1'b1, 1'b0, 18'h03333, 1'b0, 18'h00000},  // R4 off
        '{1'b0, 1'b0, 1'b0, 18'h04444, 1'b0, 18'h00000},  // R8 capture while off
        '{1'b0, 1'b0, 1'b1, 18'h05555, 1'b1, 18'h04444},  // R8 readback
        '{1'b1, 1'b1, 1'b1, 18'h06666, 1'b1, 18'h06666},  // R1
        '{1'b1, 1'b0, 1'b1, 18'h07777, 1'b1, 18'h07777},  // R9 fall with le high
        '{1'b0, 1'b0, 1'b1, 18'h08888, 1'b1, 18'h07777}   // R9 held
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_in, b_in, a_out, b_out;
    logic         a_oe, b_oe;
    logic         ab_le, ab_strb, ab_en, ba_le, ba_strb, ba_en_n;
    int           n_chk = 0;
    int           n_bad = 0;
    bit           done  = 1'b0;

    always #4 clk = ~clk;

    ubt_xcvr #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_le(ab_le), .ab_strb(ab_strb), .ab_en(ab_en),
        .ba_le(ba_le), .ba_strb(ba_strb), .ba_en_n(ba_en_n)
    );

    task automatic check(string req, logic [W:0] act, logic [W:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at falling clock, sample just before the next falling clock
    task automatic step();
        @(negedge clk);
    endtask

    task automatic settle();
        @(posedge clk);
        #2;
    endtask

    initial begin
        rst_n = 1'b1;
        a_in = '0; b_in = '0;
        ab_le = 1'b0; ab_strb = 1'b1; ab_en = 1'b1;
        ba_le = 1'b0; ba_strb = 1'b1; ba_en_n = 1'b0;
        #1 rst_n = 1'b0;
        a_in = 18'h3FFFF; b_in = 18'h2AAAA;
        #2;
        // R10: reset clears both stored words
        check("R10 b side in reset", {b_oe, b_out}, {1'b1, 18'h0});
        check("R10 a side in reset", {a_oe, a_out}, {1'b1, 18'h0});
        step();
        step();
        rst_n = 1'b1;
        ab_strb = 1'b0; ba_strb = 1'b0;
        settle();
        // R10: low strobe at first edge after release does not capture
        check("R10 no capture after release b", {b_oe, b_out}, {1'b1, 18'h0});
        check("R10 no capture after release a", {a_oe, a_out}, {1'b1, 18'h0});

        for (int i = 0; i < NV; i++) begin
            step();
            ab_le = VEC[i].le;  ab_strb = VEC[i].strb;  ab_en   =  VEC[i].en;
            ba_le = VEC[i].le;  ba_strb = VEC[i].strb;  ba_en_n = ~VEC[i].en;
            a_in  = VEC[i].din;
            b_in  = VEC[i].din ^ MASK;
            settle();
            // R1 R2 R3 R4 R8 R9 on A to B
            check($sformatf("R3 table A-to-B vector %0d", i), {b_oe, b_out},
                  {VEC[i].eoe, VEC[i].eout});
            // R5 R6 R7 on B to A
            check($sformatf("R6 table B-to-A vector %0d", i), {a_oe, a_out},
                  {VEC[i].eoe, VEC[i].eoe ? (VEC[i].eout ^ MASK) : 18'h0});
        end

        // R11: capture on B to A, A to B holds 07777
        step();
        ba_le = 1'b0; ba_strb = 1'b1; b_in = 18'h12121;
        ab_strb = 1'b0; a_in = 18'h00F0F;
        settle();
        step();
        ba_strb = 1'b0;
        settle();
        check("R6 directed capture", {a_oe, a_out}, {1'b1, 18'h12121});
        check("R11 A-to-B untouched", {b_oe, b_out}, {1'b1, 18'h07777});

        // R11: capture on A to B, B to A holds 12121
        step();
        ab_strb = 1'b1; b_in = 18'h0;
        settle();
        step();
        ab_strb = 1'b0;
        settle();
        check("R3 directed capture", {b_oe, b_out}, {1'b1, 18'h00F0F});
        check("R11 B-to-A untouched", {a_oe, a_out}, {1'b1, 18'h12121});

        // R7: active-low enable releases A only
        step();
        ba_en_n = 1'b1;
        #1;
        check("R7 a released", {a_oe, a_out}, {1'b0, 18'h0});
        check("R4 b still on", {b_oe, b_out}, {1'b1, 18'h00F0F});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule